// File: doc/BRIEF.md
# Converter Output Latency and Format Stage

This block forms the digital back end of an 8-bit pipelined sampling converter. Each conversion cycle it takes a raw offset-binary code and an over-range flag. It carries both through a fixed-length delay line and presents them as an output word with a valid indication. Before the word leaves the block, a format select picks between straight binary and two's-complement coding.

A clock front end produces the conversion enable. It either runs at the full input clock rate, or at half that rate when a divide select is pulled low. The divided enable is derived from rising edges only, so it is high on exactly every other clock. All storage advances only on enabled cycles. Upstream logic should therefore offer a new sample whenever the conversion enable is high.

Top module: `adc_out_stage`

## Requirements
- R1: A sample accepted on an enabled clock edge appears on `data_o` after exactly `LATENCY` (default 28) enabled edges, counting its own accepting edge.
- R2: With `fmt_n_i` high, `data_o` equals the raw code. With `fmt_n_i` low, `data_o` is the raw code with bit 7 inverted (two's complement), so raw 0x80 gives 0x00 and raw 0x00 gives 0x80.
- R3: `sample_i` and `data_o` are 8 bits wide with bit 0 as the least significant bit, and every one of the 256 codes passes through.
- R4: `ovr_o` is the over-range flag that was accepted together with the sample now shown on `data_o`.
- R5: With `div_n_i` low, `conv_en_o` toggles on every rising clock edge, so it is high on one clock in two.
- R6: With `div_n_i` high, `conv_en_o` is high on every clock after the first edge out of reset.
- R7: On an edge where `conv_en_o` was low, `data_o`, `ovr_o` and `valid_o` keep their values and no sample is taken.
- R8: After reset, `valid_o` stays low until `LATENCY` samples have been accepted. It then rises with the first accepted sample's output word and stays high until the next reset.
- R9: A change of `fmt_n_i` applies from the next output word onward, without flushing the words already in flight.
- R10: While `rst_ni` is low, `data_o`, `ovr_o`, `valid_o` and `conv_en_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_n_i | input | 1 | Low: conversion enable at half rate; high: full rate |
| fmt_n_i | input | 1 | Low: two's-complement output; high: straight binary |
| sample_i | input | 8 | Raw offset-binary code from the converter core |
| ovr_i | input | 1 | Over-range flag for `sample_i` |
| conv_en_o | output | 1 | Conversion enable; a sample is taken on edges where it is high |
| data_o | output | 8 | Delayed, formatted output word |
| ovr_o | output | 1 | Over-range flag aligned with `data_o` |
| valid_o | output | 1 | Output word holds a real sample |

## Verification
The assertions check the enable cadence in both divide settings on every cycle. They also check that the outputs hold on idle cycles and that valid never drops once it is high. The exact latency, the alignment of the over-range flag with its own word and the per-word format switch can only be shown by the bench. It does this by replaying every code through the pipeline in both clock modes and comparing each output word against a history of accepted samples.

// File: rtl/adc_out_pkg.sv
package adc_out_pkg;
  localparam int unsigned CODE_W = 8;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              ovr;
  } smp_t;

  localparam int unsigned SMP_W = $bits(smp_t);
endpackage

// File: rtl/adc_clk_en.sv
module adc_clk_en (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic div_n_i,
  output logic en_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else if (div_n_i) en_q <= 1'b1;
    else en_q <= ~en_q;
  end

  assign en_o = en_q;

  a_r5_half_rate_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!div_n_i && !en_q) |=> en_q);
  a_r5_half_rate_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!div_n_i && en_q) |=> !en_q);
  a_r6_full_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_n_i |=> en_q);
endmodule

// File: rtl/adc_delay_line.sv
module adc_delay_line #(
  parameter int unsigned DEPTH = 27,
  parameter int unsigned W     = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= '0;
    end else if (en_i) begin
      stg_q[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[DEPTH-1];
endmodule

// File: rtl/adc_fmt_out.sv
module adc_fmt_out
  import adc_out_pkg::*;
#(
  parameter int unsigned LATENCY = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              fmt_n_i,
  input  smp_t              smp_i,
  output logic [CODE_W-1:0] data_o,
  output logic              ovr_o,
  output logic              valid_o
);
  localparam int unsigned CNT_W = $clog2(LATENCY);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(LATENCY - 1);

  logic [CNT_W-1:0] fill_q;
  logic [CODE_W-1:0] code_fmt;

  // two's complement of offset binary: flip the sign bit
  assign code_fmt = fmt_n_i ? smp_i.code
                            : {~smp_i.code[CODE_W-1], smp_i.code[CODE_W-2:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q  <= '0;
      data_o  <= '0;
      ovr_o   <= 1'b0;
      valid_o <= 1'b0;
    end else if (en_i) begin
      data_o  <= code_fmt;
      ovr_o   <= smp_i.ovr;
      valid_o <= (fill_q == CNT_TOP);
      if (fill_q != CNT_TOP) fill_q <= fill_q + 1'b1;
    end
  end

  a_r8_valid_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);
  a_r7_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(data_o) && $stable(ovr_o) && $stable(valid_o)));
  a_r8_fill_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= CNT_TOP);
endmodule

// File: rtl/adc_out_stage.sv
module adc_out_stage
  import adc_out_pkg::*;
#(
  parameter int unsigned LATENCY = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              div_n_i,
  input  logic              fmt_n_i,
  input  logic [CODE_W-1:0] sample_i,
  input  logic              ovr_i,
  output logic              conv_en_o,
  output logic [CODE_W-1:0] data_o,
  output logic              ovr_o,
  output logic              valid_o
);
  smp_t smp_in, smp_dly;

  adc_clk_en u_clk_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .div_n_i (div_n_i),
    .en_o    (conv_en_o)
  );

  assign smp_in.code = sample_i;
  assign smp_in.ovr  = ovr_i;

  // LATENCY-1 stages here, the formatting register is the last one
  adc_delay_line #(
    .DEPTH (LATENCY - 1),
    .W     (SMP_W)
  ) u_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (conv_en_o),
    .d_i    (smp_in),
    .q_o    (smp_dly)
  );

  adc_fmt_out #(
    .LATENCY (LATENCY)
  ) u_fmt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (conv_en_o),
    .fmt_n_i (fmt_n_i),
    .smp_i   (smp_dly),
    .data_o  (data_o),
    .ovr_o   (ovr_o),
    .valid_o (valid_o)
  );

  a_r10_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && !conv_en_o && !ovr_o && data_o == '0));
endmodule

// File: tb/adc_out_stage_tb_top.sv
module adc_out_stage_tb_top;
  localparam int LAT = 28;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       div_n_i = 1'b1;
  logic       fmt_n_i = 1'b1;
  logic [7:0] sample_i = '0;
  logic       ovr_i = 1'b0;
  logic       conv_en_o, ovr_o, valid_o;
  logic [7:0] data_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  logic [7:0] hist_d [1024];
  logic       hist_o [1024];

  always #10 clk_i = ~clk_i;

  adc_out_stage #(.LATENCY(LAT)) dut_i (
    .clk_i, .rst_ni, .div_n_i, .fmt_n_i, .sample_i, .ovr_i,
    .conv_en_o, .data_o, .ovr_o, .valid_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <= %0d cycles", cyc, 20000);
      finish_run();
    end
  end

  function automatic logic [7:0] fmt(input logic [7:0] c, input logic f);
    return f ? c : (c ^ 8'h80);
  endfunction

  // Runs one phase; fmt flips at the given accepted-sample count (-1: never)
  task automatic run_phase(input logic div_n, input logic fmt0, input int n_smp,
                           input int flip_at);
    int k = 0;          // samples accepted so far
    int fed = 0;
    bit en_prev = 0;
    logic [7:0] d_prev = '0;
    logic o_prev = 0, v_prev = 0, en_seen = 0;
    rst_ni = 1'b0; div_n_i = div_n; fmt_n_i = fmt0;
    sample_i = '0; ovr_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(data_o == 8'h00 && ovr_o == 1'b0, "R10 data/ovr", {data_o, ovr_o}, 0);
    chk(valid_o == 1'b0 && conv_en_o == 1'b0, "R10 valid/en", {valid_o, conv_en_o}, 0);
    rst_ni = 1'b1;
    while (k < n_smp + LAT) begin
      @(negedge clk_i);
      if (en_prev) begin
        k++;
        chk(valid_o == (k >= LAT), "R8 valid", valid_o, (k >= LAT));
        if (k >= LAT) begin
          chk(data_o == fmt(hist_d[k-LAT], fmt_n_i), "R1 R2 R3 R9 data",
              data_o, fmt(hist_d[k-LAT], fmt_n_i));
          chk(ovr_o == hist_o[k-LAT], "R4 ovr", ovr_o, hist_o[k-LAT]);
        end
      end else begin
        chk(data_o == d_prev && ovr_o == o_prev && valid_o == v_prev, "R7 hold",
            {data_o, ovr_o, valid_o}, {d_prev, o_prev, v_prev});
      end
      if (!div_n) begin
        if (en_seen) chk(conv_en_o == ~en_prev, "R5 alternate", conv_en_o, ~en_prev);
      end else begin
        chk(conv_en_o == 1'b1, "R6 full rate", conv_en_o, 1);
      end
      en_seen = 1;
      d_prev = data_o; o_prev = ovr_o; v_prev = valid_o;
      if (k == flip_at && en_prev) fmt_n_i = ~fmt_n_i;  // R9: mid-stream switch
      en_prev = conv_en_o;
      if (conv_en_o) begin
        logic [7:0] c = 8'(fed * 37 + 11);
        if (fed < 256) c = 8'(fed);
        sample_i = c;
        ovr_i = c[0] ^ c[3] ^ c[7];
        hist_d[fed] = c;
        hist_o[fed] = ovr_i;
        fed++;
      end
    end
  endtask

  initial begin
    run_phase(1'b1, 1'b1, 300, 150);
    run_phase(1'b0, 1'b0, 300, 200);
    run_phase(1'b0, 1'b1, 40, -1);
    finish_run();
  end
endmodule